// File: doc/BRIEF.md
# Page-Mode EEPROM Write Front-End

This block is the device-side write interface of a parallel EEPROM array. It runs on a system clock and watches three asynchronous active-low strobes: chip select, write enable and output enable. It also watches an address bus and a data bus. A write cycle opens when the later of chip select and write enable goes low, and the address is taken at that moment. The cycle closes when the earlier of the two returns high, and the data word is taken then. Words collect in a page buffer while a retriggerable window timer runs. Every falling edge of write enable restarts that timer from zero.

When the window lapses with no write cycle in progress, the block enters an internal programming phase and raises `busy`. While it is busy it ignores the strobes. At the end of the phase it copies every valid buffered word into the cell array in one cycle, clears the buffer and drops `busy`. The cell array is a plain register memory with a combinational read port. The read port exists only to observe the stored contents.

The control state machine has four states:
- `ST_IDLE`: no page is open.
- `ST_OPEN`: a page is open and collecting words.
- `ST_PROG`: the programming phase is counting.
- `ST_COMMIT`: the one-cycle copy into the array.

The transitions are:
- `ST_IDLE`→`ST_OPEN` on an accepted cycle start, the page-open transition.
- `ST_OPEN`→`ST_PROG` when the window has lapsed and no cycle is in progress, the window-expiry transition.
- `ST_PROG`→`ST_COMMIT` when the programming count completes, the program-done transition.
- `ST_COMMIT`→`ST_IDLE` unconditionally, the release transition.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy` is 0 and every array word reads as zero.
- R2: The word is stored at the address present when the later of `cs_n` and `we_n` falls. Later address changes within the same cycle have no effect.
- R3: The stored data is the value present when the earlier of `cs_n` and `we_n` rises. Later data changes before the other strobe rises have no effect.
- R4: Each falling edge of `we_n` restarts a window of `WIN_CYCLES` clocks, counted from its synchronized detection. `busy` stays low while falling edges keep arriving inside the window. `busy` rises a few clocks after the window lapses.
- R5: `busy` stays high for `PROG_CYCLES` plus one clocks. Array contents keep their old values while `busy` is high and take the new values when it falls.
- R6: While `busy` is high, write cycles store nothing and do not restart the window. No further programming phase follows them.
- R7: A write cycle that starts while `oe_n` is low stores nothing and leaves the timer untouched, so no programming phase follows it.
- R8: A page holds 2^`PAGE_AW` words, selected by the low `PAGE_AW` address bits. The upper address bits of the first word in the page set the page base. A word whose upper bits differ from that base is dropped.
- R9: A low pulse on `we_n` while `cs_n` stays high stores no word and causes no programming phase.
- R10: Two writes to the same page slot within one window leave the later data in the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select strobe, active low, asynchronous |
| we_n | input | 1 | Write enable strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous; writes are accepted only while it is high |
| addr | input | ADDR_W (15) | Word address |
| data | input | DATA_W (32) | Write data |
| rd_addr | input | ARRAY_AW (10) | Read address into the modeled cell array |
| rd_data | output | DATA_W (32) | Array word at `rd_addr`, combinational |
| busy | output | 1 | High during programming and the commit cycle |

## Verification
A wrong state in the strobe edge logic shows up as words stored at a neighbouring address or with stale data. It becomes visible on `rd_data` as soon as `busy` falls after that page. A timer that fails to retrigger, or that runs when it should not, moves the rise of `busy` by a whole window. An ignored cycle that is wrongly accepted raises `busy` about one window after the stray strobe. A state machine stuck in the programming phase keeps `busy` high far past `PROG_CYCLES`. A missed commit leaves the old word on `rd_data` once `busy` is low.

// File: rtl/eeprom_pw_pkg.sv
package eeprom_pw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_PROG   = 2'd2,
        ST_COMMIT = 2'd3
    } pw_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b] <= 1'b1;
                synced[b] <= 1'b1;
            end else begin
                stage1[b] <= raw[b];
                synced[b] <= stage1[b];
            end
        end
    end
endmodule

// File: rtl/window_timer.sv
module window_timer #(
    parameter int WIN_CYCLES = 7500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic run
);
    localparam int CW = $clog2(WIN_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (trig) begin
            cnt <= '0;
            run <= 1'b1;
        end else if (run) begin
            if (cnt == LAST) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/page_buffer.sv
module page_buffer #(
    parameter int PAGE_AW = 3,
    parameter int DATA_W  = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [PAGE_AW-1:0]                 wr_idx,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic                               clr,
    output logic [(1<<PAGE_AW)-1:0][DATA_W-1:0] words,
    output logic [(1<<PAGE_AW)-1:0]            valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (clr) begin
            valid <= '0;
        end else if (wr) begin
            valid[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr) begin
            words[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/cell_array.sv
module cell_array #(
    parameter int ADDR_W   = 15,
    parameter int DATA_W   = 32,
    parameter int PAGE_AW  = 3,
    parameter int ARRAY_AW = 10
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               commit,
    input  logic [ADDR_W-PAGE_AW-1:0]          base,
    input  logic [(1<<PAGE_AW)-1:0][DATA_W-1:0] words,
    input  logic [(1<<PAGE_AW)-1:0]            valid,
    input  logic [ARRAY_AW-1:0]                rd_addr,
    output logic [DATA_W-1:0]                  rd_data
);
    localparam int DEPTH      = 1 << ARRAY_AW;
    localparam int PAGE_WORDS = 1 << PAGE_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem[k] <= '0;
            end
        end else if (commit) begin
            for (int i = 0; i < PAGE_WORDS; i++) begin
                if (valid[i]) begin
                    mem[ARRAY_AW'({base, PAGE_AW'(i)})] <= words[i];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eeprom_pw_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 32,
    parameter int PAGE_AW     = 3,
    parameter int ARRAY_AW    = 10,
    parameter int WIN_CYCLES  = 7500,
    parameter int PROG_CYCLES = 500000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   data,
    input  logic [ARRAY_AW-1:0] rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                busy
);
    localparam int TAG_W = ADDR_W - PAGE_AW;
    localparam int PCW   = $clog2(PROG_CYCLES + 1);
    localparam logic [PCW-1:0] PROG_LAST = PCW'(PROG_CYCLES - 1);

    // Strobe synchronization
    logic [2:0] strb_s;
    logic       cs_s, we_s, oe_s;

    strobe_sync #(.W(3)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({oe_n, we_n, cs_n}),
        .synced (strb_s)
    );

    assign cs_s = strb_s[0];
    assign we_s = strb_s[1];
    assign oe_s = strb_s[2];

    // Edge detection on the combined strobe and on write enable
    logic comb_s, comb_q, we_q;
    logic comb_fall, comb_rise, we_fall;

    assign comb_s = cs_s | we_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            comb_q <= 1'b1;
            we_q   <= 1'b1;
        end else begin
            comb_q <= comb_s;
            we_q   <= we_s;
        end
    end

    assign comb_fall = comb_q & ~comb_s;
    assign comb_rise = ~comb_q & comb_s;
    assign we_fall   = we_q & ~we_s;

    // State and control
    pw_state_e state_q, state_d;
    logic      lock, commit;
    logic      start_acc, timer_trig, timer_run;
    logic      in_cycle, cur_hit, buf_wr;
    logic [PAGE_AW-1:0] cur_idx;
    logic [TAG_W-1:0]   base_q;
    logic [PCW-1:0]     prog_cnt;

    assign start_acc  = comb_fall & oe_s & ~lock;
    assign timer_trig = we_fall & oe_s & ~lock;
    assign buf_wr     = comb_rise & in_cycle & cur_hit;

    window_timer #(.WIN_CYCLES(WIN_CYCLES)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (timer_trig),
        .run   (timer_run)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_cycle <= 1'b0;
            cur_hit  <= 1'b0;
            cur_idx  <= '0;
            base_q   <= '0;
        end else if (start_acc) begin
            in_cycle <= 1'b1;
            cur_idx  <= addr[PAGE_AW-1:0];
            cur_hit  <= (state_q == ST_IDLE) || (addr[ADDR_W-1:PAGE_AW] == base_q);
            if (state_q == ST_IDLE) begin
                base_q <= addr[ADDR_W-1:PAGE_AW];
            end
        end else if (comb_rise) begin
            in_cycle <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_cnt <= '0;
        end else if (state_q == ST_PROG) begin
            prog_cnt <= prog_cnt + 1'b1;
        end else begin
            prog_cnt <= '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_acc) state_d = ST_OPEN;
            ST_OPEN:   if (!timer_run && !in_cycle && !start_acc) state_d = ST_PROG;
            ST_PROG:   if (prog_cnt == PROG_LAST) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        lock   = 1'b0;
        commit = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_OPEN: lock = 1'b0;
            ST_PROG:          lock = 1'b1;
            ST_COMMIT: begin
                lock   = 1'b1;
                commit = 1'b1;
            end
        endcase
    end

    assign busy = lock;

    // Page buffer and modeled array
    logic [(1<<PAGE_AW)-1:0][DATA_W-1:0] pg_words;
    logic [(1<<PAGE_AW)-1:0]            pg_valid;

    page_buffer #(.PAGE_AW(PAGE_AW), .DATA_W(DATA_W)) buf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (buf_wr),
        .wr_idx  (cur_idx),
        .wr_data (data),
        .clr     (commit),
        .words   (pg_words),
        .valid   (pg_valid)
    );

    cell_array #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PAGE_AW  (PAGE_AW),
        .ARRAY_AW (ARRAY_AW)
    ) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .base    (base_q),
        .words   (pg_words),
        .valid   (pg_valid),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/eeprom_page_writer_chk.sv
module eeprom_page_writer_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic commit,
    input logic timer_run,
    input logic timer_trig,
    input logic buf_wr,
    input logic start_acc,
    input logic oe_s
);
    // R6
    no_store_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_wr);

    // R6
    no_retrig_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !timer_trig);

    // R4
    busy_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!timer_run));

    // R4
    window_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timer_trig |=> timer_run);

    // R5
    release_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(commit));

    // R7
    start_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |-> oe_s);
endmodule

bind eeprom_page_writer eeprom_page_writer_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .commit     (commit),
    .timer_run  (timer_run),
    .timer_trig (timer_trig),
    .buf_wr     (buf_wr),
    .start_acc  (start_acc),
    .oe_s       (oe_s)
);

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 40;
    localparam int PROG = 60;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, we_n, oe_n;
    logic [14:0] addr;
    logic [31:0] data;
    logic [9:0]  rd_addr;
    logic [31:0] rd_data;
    logic        busy;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_page_writer #(
        .ADDR_W(15), .DATA_W(32), .PAGE_AW(3), .ARRAY_AW(10),
        .WIN_CYCLES(WIN), .PROG_CYCLES(PROG)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .data(data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_word(input string req, input logic [9:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wr_we(input logic [14:0] a, input logic [31:0] d);
        cs_n = 1'b0; addr = a; data = d;
        idle(1);
        we_n = 1'b0;
        idle(4);
        we_n = 1'b1;
        idle(4);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic wait_rise(input string req);
        int n = 0;
        while (!busy && n < 500) begin idle(1); n++; end
        chk(req, busy, 1'b1);
    endtask

    task automatic wait_fall(input string req);
        int n = 0;
        while (busy && n < 500) begin idle(1); n++; end
        chk(req, busy, 1'b0);
        idle(2);
    endtask

    task automatic watch_quiet(input string req, input int n);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            idle(1);
            if (busy) hits++;
        end
        chk(req, hits, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", busy, 1'b0);
        chk_word("R1 word 0", 10'h000, 32'h0);
        chk_word("R1 word 3ff", 10'h3ff, 32'h0);
    endtask

    task automatic t_page();
        wr_we(15'h010, 32'h1111_0010);
        wr_we(15'h013, 32'h1111_0013);
        wr_we(15'h017, 32'h1111_0017);
        wr_we(15'h013, 32'hAAAA_0013);
        wr_we(15'h020, 32'h2222_0020);
        idle(WIN - 15);
        chk("R4 busy low inside window", busy, 1'b0);
        idle(15);
        chk("R4 busy high after window", busy, 1'b1);
        chk_word("R5 old value while busy", 10'h010, 32'h0);
        idle(PROG - 20);
        chk("R5 busy held through programming", busy, 1'b1);
        wait_fall("R5 busy released");
        chk_word("R8 slot 0", 10'h010, 32'h1111_0010);
        chk_word("R10 slot 3 later data", 10'h013, 32'hAAAA_0013);
        chk_word("R8 slot 7", 10'h017, 32'h1111_0017);
        chk_word("R8 unwritten slot", 10'h011, 32'h0);
        chk_word("R8 other page dropped", 10'h020, 32'h0);
    endtask

    task automatic t_cs_ctl();
        addr = 15'h041; data = 32'h0;
        we_n = 1'b0;
        idle(4);
        cs_n = 1'b0;
        idle(4);
        addr = 15'h045; data = 32'hD1D1_0041;
        idle(1);
        cs_n = 1'b1;
        idle(4);
        data = 32'hD2D2_0045;
        idle(4);
        we_n = 1'b1;
        idle(2);
        wait_rise("R5 busy rises after cs write");
        wait_fall("R5 busy falls after cs write");
        chk_word("R2 R3 address and data captured", 10'h041, 32'hD1D1_0041);
        chk_word("R2 late address unused", 10'h045, 32'h0);
    endtask

    task automatic t_busy_ignore();
        wr_we(15'h080, 32'hAAAA_0080);
        wait_rise("R6 busy rises");
        wr_we(15'h081, 32'hBBBB_0081);
        wr_we(15'h080, 32'hCCCC_0080);
        wait_fall("R6 busy falls");
        chk_word("R6 word kept", 10'h080, 32'hAAAA_0080);
        chk_word("R6 word not stored", 10'h081, 32'h0);
        watch_quiet("R6 no further programming", WIN + 20);
    endtask

    task automatic t_oe_low();
        oe_n = 1'b0;
        idle(3);
        wr_we(15'h060, 32'h6666_0060);
        oe_n = 1'b1;
        watch_quiet("R7 no programming", WIN + PROG + 20);
        chk_word("R7 word not stored", 10'h060, 32'h0);
    endtask

    task automatic t_single_strobe();
        cs_n = 1'b1; addr = 15'h0A0; data = 32'h9999_00A0;
        idle(1);
        we_n = 1'b0;
        idle(4);
        we_n = 1'b1;
        watch_quiet("R9 no programming", WIN + PROG + 20);
        chk_word("R9 word not stored", 10'h0A0, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        addr = '0; data = '0; rd_addr = '0;
        idle(3);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_page();
        t_cs_ctl();
        t_busy_ignore();
        t_oe_low();
        t_single_strobe();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule